// File: doc/BRIEF.md
# Complex IQ Lane Mapper

This block takes one set of decimated complex samples per frame, an in-phase and a quadrature word for each of two channels (A and B), and spreads them across up to four serial lanes as octet streams. Each sample becomes a 16-bit lane word made of the 15-bit sample value with the channel's overrange flag appended as the least-significant bit. The word is emitted high octet first.

The lane count is chosen by a two-bit mode input. It can be one, two or four lanes, and the choice sets how the I and Q words are interleaved. Fewer lanes give longer frames. The block presents a ready signal. A sample set is taken only at a frame boundary, so a producer that offers a new set mid-frame keeps it on the inputs until ready rises. Every active lane marks the first octet of each frame with a start flag.

Top module: `iq_lane_mapper`

## Requirements
- R1: A lane word is `{sample[14:0], ovr}`, so the overrange flag is bit 0. The flag of channel A is used for both AI and AQ, and the flag of channel B for BI and BQ. Bits 15..8 of a word go out in the earlier octet and bits 7..0 in the next one.
- R2: With `laneMode` = 0 (one lane), lane 0 carries an 8-octet frame of AI, AQ, BI, BQ in that order.
- R3: With `laneMode` = 1 (two lanes), lane 0 carries AI then AQ and lane 1 carries BI then BQ, in 4-octet frames.
- R4: With `laneMode` = 2 (four lanes), lanes 0, 1, 2 and 3 carry AI, AQ, BI and BQ respectively, in 2-octet frames.
- R5: `laneMode` = 3 behaves exactly like `laneMode` = 2.
- R6: A lane outside the active set, or any lane while no frame is in progress, drives zero data with its valid bit low.
- R7: `laneStart[n]` is high only on octet 0 of a frame, and only on active lanes.
- R8: `sampleReady` is high when no frame is in progress, and on the last octet of a frame. A set is accepted on a clock edge where `sampleValid` and `sampleReady` are both high. Its octet 0 appears in the next cycle. A set offered continuously produces frames with no idle cycle between them.
- R9: While a frame is in progress, changes on the sample inputs, on the overrange flags or on `laneMode` do not alter that frame. A set held while `sampleReady` is low is neither lost nor duplicated.
- R10: After reset, all lanes are invalid with zero data and `sampleReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A complex sample set is offered |
| sampleReady | output | 1 | The set is taken at this clock edge if valid |
| laneMode | input | 2 | 0: one lane, 1: two lanes, 2 or 3: four lanes |
| aI | input | 15 | Channel A in-phase sample |
| aQ | input | 15 | Channel A quadrature sample |
| bI | input | 15 | Channel B in-phase sample |
| bQ | input | 15 | Channel B quadrature sample |
| aOvr | input | 1 | Channel A overrange flag |
| bOvr | input | 1 | Channel B overrange flag |
| laneData | output | 32 | Octet per lane, lane n in bits 8n+7..8n |
| laneValid | output | 4 | Lane n carries an octet this cycle |
| laneStart | output | 4 | Lane n is on octet 0 of a frame |

## Verification
Every lane mode, including the alias code, is driven with zero words, all-ones words, and arithmetic sample sequences in which each of the four words differs in both octets. Each overrange flag is set alone in some of these sets, so a misplaced flag, a swapped octet or a wrong I/Q interleave shows up as a specific mismatch. Sets are sent both with idle gaps and back to back. In the back-to-back case the next set is held on the inputs while a frame runs, which tests the ready timing and that no set is lost. After each acceptance the inputs and the mode are changed at once, which shows whether a running frame picks up stray changes.

// File: rtl/iqmap_pkg.sv
package iqmap_pkg;
  localparam int SAMPLE_W      = 15;
  localparam int WORD_W        = SAMPLE_W + 1;
  localparam int OCT_W         = 8;
  localparam int OCT_PER_WORD  = WORD_W / OCT_W;
  localparam int NUM_WORDS     = 4;
  localparam int NUM_LANES     = 4;
  localparam int FRAME_MAX     = NUM_WORDS * OCT_PER_WORD;
  localparam int IDX_W         = $clog2(FRAME_MAX);
  localparam int WSEL_W        = $clog2(NUM_WORDS);

  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_TWO  = 2'd1,
    MODE_FOUR = 2'd2,
    MODE_ALT  = 2'd3
  } laneMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             active;
    logic [IDX_W-1:0] octIdx;
    logic [1:0]       lanesLog2;
  } mapStrobe_t;
endpackage

// File: rtl/iqmap_ctrl.sv
module iqmap_ctrl
  import iqmap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleValid,
  input  logic [1:0] laneMode,
  output logic       sampleReady,
  output mapStrobe_t strb
);
  logic             active;
  logic [IDX_W-1:0] octIdx;
  logic [1:0]       lanesLog2;
  logic [1:0]       nextLog2;
  logic [IDX_W-1:0] lastIdx;
  logic             lastOct;
  logic             load;

  always_comb begin
    case (laneMode_e'(laneMode))
      MODE_ONE: nextLog2 = 2'd0;
      MODE_TWO: nextLog2 = 2'd1;
      default:  nextLog2 = 2'd2;
    endcase
  end

  assign lastIdx     = IDX_W'((FRAME_MAX >> lanesLog2) - 1);
  assign lastOct     = active && (octIdx == lastIdx);
  assign sampleReady = !active || lastOct;
  assign load        = sampleValid && sampleReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      octIdx    <= '0;
      lanesLog2 <= 2'd0;
    end else if (load) begin
      active    <= 1'b1;
      octIdx    <= '0;
      lanesLog2 <= nextLog2;
    end else if (lastOct) begin
      active    <= 1'b0;
    end else if (active) begin
      octIdx    <= octIdx + 1'b1;
    end
  end

  assign strb.load      = load;
  assign strb.active    = active;
  assign strb.octIdx    = octIdx;
  assign strb.lanesLog2 = lanesLog2;

  assert_octet_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (octIdx <= lastIdx));

  assert_mode_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !lastOct) |=> (active && $stable(lanesLog2)));
endmodule

// File: rtl/iqmap_datapath.sv
module iqmap_datapath
  import iqmap_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  mapStrobe_t                 strb,
  input  logic [SAMPLE_W-1:0]        aI,
  input  logic [SAMPLE_W-1:0]        aQ,
  input  logic [SAMPLE_W-1:0]        bI,
  input  logic [SAMPLE_W-1:0]        bQ,
  input  logic                       aOvr,
  input  logic                       bOvr,
  output logic [NUM_LANES*OCT_W-1:0] laneData,
  output logic [NUM_LANES-1:0]       laneValid,
  output logic [NUM_LANES-1:0]       laneStart
);
  logic [WORD_W-1:0] words [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) words[i] <= '0;
    end else if (strb.load) begin
      words[0] <= {aI, aOvr};
      words[1] <= {aQ, aOvr};
      words[2] <= {bI, bOvr};
      words[3] <= {bQ, bOvr};
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic              inUse;
    logic [WSEL_W-1:0] wSel;
    logic [WORD_W-1:0] wSrc;
    logic [OCT_W-1:0]  octet;

    always_comb begin
      inUse = strb.active && (g < (1 << strb.lanesLog2));
      case (strb.lanesLog2)
        2'd0:    wSel = WSEL_W'(strb.octIdx >> 1);
        2'd1:    wSel = WSEL_W'(g * 2) + WSEL_W'(strb.octIdx >> 1);
        default: wSel = WSEL_W'(g);
      endcase
      wSrc  = words[wSel];
      octet = strb.octIdx[0] ? wSrc[OCT_W-1:0] : wSrc[WORD_W-1 -: OCT_W];
    end

    assign laneValid[g]                = inUse;
    assign laneStart[g]                = inUse && (strb.octIdx == '0);
    assign laneData[g*OCT_W +: OCT_W]  = inUse ? octet : '0;
  end

  assert_ovr_in_lsb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (words[0][0] == $past(aOvr)) && (words[3][0] == $past(bOvr)));

  assert_start_on_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (laneStart != '0) |-> (laneStart == laneValid));
endmodule

// File: rtl/iq_lane_mapper.sv
module iq_lane_mapper
  import iqmap_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sampleValid,
  output logic                       sampleReady,
  input  logic [1:0]                 laneMode,
  input  logic [SAMPLE_W-1:0]        aI,
  input  logic [SAMPLE_W-1:0]        aQ,
  input  logic [SAMPLE_W-1:0]        bI,
  input  logic [SAMPLE_W-1:0]        bQ,
  input  logic                       aOvr,
  input  logic                       bOvr,
  output logic [NUM_LANES*OCT_W-1:0] laneData,
  output logic [NUM_LANES-1:0]       laneValid,
  output logic [NUM_LANES-1:0]       laneStart
);
  mapStrobe_t strb;

  iqmap_ctrl uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sampleValid (sampleValid),
    .laneMode    (laneMode),
    .sampleReady (sampleReady),
    .strb        (strb)
  );

  iqmap_datapath uData (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .aI        (aI),
    .aQ        (aQ),
    .bI        (bI),
    .bQ        (bQ),
    .aOvr      (aOvr),
    .bOvr      (bOvr),
    .laneData  (laneData),
    .laneValid (laneValid),
    .laneStart (laneStart)
  );

  assert_first_octet_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && sampleReady) |=> (laneStart[0] && laneValid[0]));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (laneValid == '0) |-> (laneData == '0));
endmodule

// File: tb/iq_lane_mapper_test.sv
module iq_lane_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic        sampleReady;
  logic [1:0]  laneMode = 2'd0;
  logic [14:0] aI = '0, aQ = '0, bI = '0, bQ = '0;
  logic        aOvr = 1'b0, bOvr = 1'b0;
  logic [31:0] laneData;
  logic [3:0]  laneValid, laneStart;

  int total = 0;
  int bad = 0;

  // reference model state
  bit          mBusy = 0;
  int          mN = 0;
  int          mLog2 = 0;
  int          mMode = 0;
  logic [15:0] mW [4];

  always #5 clk = ~clk;

  iq_lane_mapper uut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .laneMode(laneMode), .aI(aI), .aQ(aQ), .bI(bI), .bQ(bQ), .aOvr(aOvr), .bOvr(bOvr),
    .laneData(laneData), .laneValid(laneValid), .laneStart(laneStart)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string modeTag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic checkOutputs();
    logic [31:0] eData = '0;
    logic [3:0]  eValid = '0, eStart = '0;
    int flen = 8 >> mLog2;
    bit eReady = !mBusy || (mN == flen - 1);
    for (int l = 0; l < 4; l++) begin
      if (mBusy && l < (1 << mLog2)) begin
        int w;
        logic [15:0] word;
        if (mLog2 == 0) w = mN / 2;
        else if (mLog2 == 1) w = l * 2 + mN / 2;
        else w = l;
        word = mW[w];
        eValid[l] = 1'b1;
        eStart[l] = (mN == 0);
        eData[l*8 +: 8] = (mN % 2 == 0) ? word[15:8] : word[7:0];
      end
    end
    check(laneData == eData, {modeTag(mMode), " R1 R9 data"}, laneData, eData);
    check(laneValid == eValid, "R6 valid", {28'd0, laneValid}, {28'd0, eValid});
    check(laneStart == eStart, "R7 start", {28'd0, laneStart}, {28'd0, eStart});
    check(sampleReady == eReady, "R8 ready", {31'd0, sampleReady}, {31'd0, eReady});
  endtask

  // one cycle: check at negedge, step model at posedge
  task automatic tick(output bit acc);
    checkOutputs();
    acc = sampleValid && sampleReady;
    @(posedge clk);
    if (mBusy) begin
      if (mN == (8 >> mLog2) - 1) mBusy = 0;
      else mN++;
    end
    if (acc) begin
      mBusy = 1;
      mN = 0;
      mMode = int'(laneMode);
      mLog2 = (laneMode == 2'd0) ? 0 : (laneMode == 2'd1) ? 1 : 2;
      mW[0] = {aI, aOvr};
      mW[1] = {aQ, aOvr};
      mW[2] = {bI, bOvr};
      mW[3] = {bQ, bOvr};
    end
    @(negedge clk);
  endtask

  task automatic sendSet(input int mode, input int pat, input int gap);
    bit acc = 0;
    laneMode = 2'(mode);
    case (pat % 4)
      0: begin aI = '0; aQ = '0; bI = '0; bQ = '0; end
      1: begin aI = '1; aQ = '1; bI = '1; bQ = '1; end
      default: begin
        aI = 15'(pat * 16'h1357 + mode * 16'h0111 + 16'h0102);
        aQ = 15'(pat * 16'h2469 + 16'h0304);
        bI = 15'(pat * 16'h0abc + 16'h0506);
        bQ = 15'(pat * 16'h3f01 + 16'h0708);
      end
    endcase
    aOvr = pat[0];
    bOvr = pat[1];
    sampleValid = 1'b1;
    while (!acc) tick(acc);
    // R9: disturb inputs and mode while the frame runs
    if (gap > 0) begin
      sampleValid = 1'b0;
      aI = ~aI; aQ = ~aQ; bI = ~bI; bQ = ~bQ;
      aOvr = ~aOvr; bOvr = ~bOvr;
      laneMode = laneMode + 2'd1;
      for (int i = 0; i < gap; i++) tick(acc);
    end
  endtask

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(laneValid == 4'd0, "R10 valid", {28'd0, laneValid}, 32'd0);
    check(laneData == 32'd0, "R10 data", laneData, 32'd0);
    check(sampleReady == 1'b1, "R10 ready", {31'd0, sampleReady}, 32'd1);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 8; p++)
        sendSet(m, p, (p % 3 == 0) ? 0 : (p % 3) * 3);
    // back-to-back across mode changes
    for (int p = 0; p < 6; p++) sendSet(p % 4, p + 9, 0);
    sampleValid = 1'b0;
    for (int i = 0; i < 12; i++) tick(acc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule